// File: doc/BRIEF.md
# Paged Register Sequencer over a Pseudo-PHY Management Window

This block turns one host access to a paged register space into the sequence of 16-bit management operations that the space needs. The space is reached only through a small window of management registers at one fixed PHY address. One window register selects a page, one takes a command with a register number and an opcode, and four 16-bit data registers carry a value of up to 64 bits. The host supplies a page, a register number, a direction, a byte length and write data. It receives a done pulse, an error flag and the assembled read value.

Below the block sits a management-frame engine that takes one operation at a time: PHY address, window register, read/write flag and write data. The engine answers each operation with a done pulse and 16-bit read data. The sequencer keeps the last page it selected, so that it skips the page write when the page has not changed. After it issues a command it polls the command register until the opcode bits clear, and it gives up after a fixed number of polls.

Top module: `mdio_paged_seq`

## Requirements
- R1: Every management operation the block issues carries PHY address 0x1E.
- R2: If no page is cached, or the requested page differs from the cached page, the first operation writes window register 0x10 with the page in bits 15:8 and 0x01 in bits 7:0. If the requested page equals the cached page, this write is skipped. The cache is empty after reset.
- R3: A write loads the data registers before the command, starting with the highest register used and ending with 0x18. Register 0x18+i gets write-data bits 16i+15:16i. For a 1-byte write, register 0x18 gets 0x00 in bits 15:8 and write-data bits 7:0 in bits 7:0.
- R4: The command is a write to register 0x11 with the register number in bits 15:8. Bits 7:0 are 0x01 for a write and 0x02 for a read.
- R5: After the command, register 0x11 is read repeatedly until bits 1:0 of the value read are both zero. The other bits of that value have no effect.
- R6: If 100 polls have not shown completion, the access ends with done and err both high, and no further operation is issued. A timed-out access leaves the page cache unchanged.
- R7: After a successful read poll, the data registers are read from the highest used register down to 0x18. Each value is placed at bits 16i+15:16i of rdata. For a 1-byte read, only bits 7:0 of register 0x18 are kept. All rdata bits above the requested length are zero, and rdata is zero after a write.
- R8: A length of 1 or 2 bytes uses register 0x18 only. A length of 4 uses 0x18 and 0x19, 6 uses 0x18 to 0x1A, and 8 uses 0x18 to 0x1B.
- R9: A request with any other length gives done and err high in the cycle after it is taken. It issues no management operation and leaves the page cache unchanged.
- R10: Each operation is shown with mg_valid high for exactly one cycle. The next operation appears only after mg_done has answered the previous one.
- R11: busy is high from the cycle after a request is taken until the access ends. A request that arrives while busy is high is ignored. done is a one-cycle pulse in the cycle after the final operation is answered, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an access (taken when busy is low) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Target page |
| req_reg | input | 8 | Target register number within the page |
| req_len | input | 4 | Length in bytes (1, 2, 4, 6 or 8) |
| req_wdata | input | 64 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse when an access ends |
| err | output | 1 | Error status of the access that ended, valid with done |
| rdata | output | 64 | Assembled read value, valid with done |
| mg_valid | output | 1 | One-cycle strobe that issues a management operation |
| mg_phy | output | 5 | PHY address of the operation |
| mg_reg | output | 5 | Window register of the operation |
| mg_write | output | 1 | 1 = management write, 0 = management read |
| mg_wdata | output | 16 | Management write data |
| mg_done | input | 1 | Lower engine finished the outstanding operation |
| mg_rdata | input | 16 | Read data from the lower engine, valid with mg_done |

## Verification
The sequencer is driven with reads and writes of every legal length. Comparing these shows whether the number of data registers and their order follow the length, and whether a 1-byte value is cut to its low byte. Pages are repeated and then changed, and a poll timeout is followed by an access to the same page. These cases show whether the page write is skipped only on a cache hit, and whether a failed access leaves the cache as it was. The number of busy polls is varied, with the upper bits of the poll value set, to show that only the two opcode bits end the poll loop. The responder's latency is varied, and illegal lengths and requests that arrive while busy is high are injected, to show that extra requests are ignored and that a rejected request produces no management traffic.

// File: rtl/mdio_paged_seq.sv
module mdio_paged_seq #(
  parameter logic [4:0] PHY_ADDR = 5'h1E,
  parameter int         POLL_MAX = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_reg,
  input  logic [3:0]  req_len,
  input  logic [63:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [63:0] rdata,
  output logic        mg_valid,
  output logic [4:0]  mg_phy,
  output logic [4:0]  mg_reg,
  output logic        mg_write,
  output logic [15:0] mg_wdata,
  input  logic        mg_done,
  input  logic [15:0] mg_rdata
);
  localparam logic [4:0] REG_PAGE = 5'h10;
  localparam logic [4:0] REG_CMD  = 5'h11;
  localparam logic [4:0] REG_DATA = 5'h18;
  localparam int         PCW      = $clog2(POLL_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PAGE, S_WDATA, S_CMD, S_POLL, S_RDATA} st_t;

  st_t             state;
  logic            issued;
  logic [7:0]      page_q, cur_page, cur_reg;
  logic            page_ok, cur_wr, len1;
  logic [1:0]      widx, hi_idx;
  logic [63:0]     wbuf, rbuf;
  logic [PCW-1:0]  pcnt;
  logic            done_q, err_q;
  logic            len_ok;
  logic [1:0]      len_hi;

  always_comb begin
    len_ok = 1'b1;
    len_hi = 2'd0;
    case (req_len)
      4'd1, 4'd2: len_hi = 2'd0;
      4'd4:       len_hi = 2'd1;
      4'd6:       len_hi = 2'd2;
      4'd8:       len_hi = 2'd3;
      default:    len_ok = 1'b0;
    endcase
  end

  assign busy     = state != S_IDLE;
  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rbuf;
  assign mg_valid = busy && !issued;
  assign mg_phy   = PHY_ADDR;
  assign mg_write = state == S_PAGE || state == S_WDATA || state == S_CMD;

  always_comb begin
    mg_reg   = REG_CMD;
    mg_wdata = 16'h0000;
    case (state)
      S_PAGE:  begin mg_reg = REG_PAGE; mg_wdata = {cur_page, 8'h01}; end
      S_WDATA: begin
        mg_reg   = REG_DATA + {3'b000, widx};
        mg_wdata = len1 ? {8'h00, wbuf[7:0]} : wbuf[{widx, 4'b0000} +: 16];
      end
      S_CMD:   mg_wdata = {cur_reg, 6'b000000, cur_wr ? 2'b01 : 2'b10};
      S_RDATA: mg_reg = REG_DATA + {3'b000, widx};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      issued   <= 1'b0;
      page_q   <= 8'h00;
      page_ok  <= 1'b0;
      cur_page <= 8'h00;
      cur_reg  <= 8'h00;
      cur_wr   <= 1'b0;
      len1     <= 1'b0;
      widx     <= 2'd0;
      hi_idx   <= 2'd0;
      wbuf     <= 64'h0;
      rbuf     <= 64'h0;
      pcnt     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mg_valid) issued <= 1'b1;
      if (state == S_IDLE) begin
        if (req_valid) begin
          if (!len_ok) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            cur_page <= req_page;
            cur_reg  <= req_reg;
            cur_wr   <= req_write;
            len1     <= req_len == 4'd1;
            wbuf     <= req_wdata;
            rbuf     <= 64'h0;
            widx     <= len_hi;
            hi_idx   <= len_hi;
            pcnt     <= '0;
            if (page_ok && page_q == req_page)
              state <= req_write ? S_WDATA : S_CMD;
            else
              state <= S_PAGE;
          end
        end
      end else if (issued && mg_done) begin
        issued <= 1'b0;
        case (state)
          S_PAGE:  state <= cur_wr ? S_WDATA : S_CMD;
          S_WDATA: if (widx == 2'd0) state <= S_CMD; else widx <= widx - 2'd1;
          S_CMD:   state <= S_POLL;
          S_POLL: begin
            if (mg_rdata[1:0] == 2'b00) begin
              if (cur_wr) begin
                state   <= S_IDLE;
                done_q  <= 1'b1;
                err_q   <= 1'b0;
                page_q  <= cur_page;
                page_ok <= 1'b1;
              end else begin
                widx  <= hi_idx;
                state <= S_RDATA;
              end
            end else if (pcnt == PCW'(POLL_MAX - 1)) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
          S_RDATA: begin
            rbuf[{widx, 4'b0000} +: 16] <= len1 ? {8'h00, mg_rdata[7:0]} : mg_rdata;
            if (widx == 2'd0) begin
              state   <= S_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b0;
              page_q  <= cur_page;
              page_ok <= 1'b1;
            end else begin
              widx <= widx - 2'd1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_paged_seq_chk.sv
module mdio_paged_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  req_len,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mg_valid,
  input logic [4:0]  mg_phy,
  input logic [4:0]  mg_reg,
  input logic        mg_write,
  input logic [15:0] mg_wdata,
  input logic        mg_done
);
  logic outst;
  logic bad_len;
  assign bad_len = !(req_len == 4'd1 || req_len == 4'd2 || req_len == 4'd4 ||
                     req_len == 4'd6 || req_len == 4'd8);

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (mg_valid) outst <= 1'b1;
    else if (mg_done) outst <= 1'b0;
  end

  p_phy_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mg_valid |-> mg_phy == 5'h1E);
  p_cmd_opcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_valid && mg_write && mg_reg == 5'h11) |-> (mg_wdata[7:0] == 8'h01 || mg_wdata[7:0] == 8'h02));
  p_read_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_valid && !mg_write) |-> (mg_reg == 5'h11 || mg_reg[4:2] == 3'b110));
  p_reject_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && bad_len) |=> (done && err && !busy));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mg_valid);
  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mg_valid |=> !mg_valid);
  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mg_valid |-> !outst);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind mdio_paged_seq mdio_paged_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
  .busy(busy), .done(done), .err(err), .mg_valid(mg_valid), .mg_phy(mg_phy),
  .mg_reg(mg_reg), .mg_write(mg_write), .mg_wdata(mg_wdata), .mg_done(mg_done)
);

// File: tb/sim_mdio_paged_seq.sv
module sim_mdio_paged_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_page = 0, req_reg = 0;
  logic [3:0]  req_len = 0;
  logic [63:0] req_wdata = 0;
  logic        busy, done, err;
  logic [63:0] rdata;
  logic        mg_valid, mg_write;
  logic [4:0]  mg_phy, mg_reg;
  logic [15:0] mg_wdata;
  logic        mg_done = 0;
  logic [15:0] mg_rdata = 0;

  mdio_paged_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_page(req_page), .req_reg(req_reg), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .mg_valid(mg_valid), .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_write(mg_write),
    .mg_wdata(mg_wdata), .mg_done(mg_done), .mg_rdata(mg_rdata)
  );

  typedef struct { logic [4:0] r; bit w; logic [15:0] d; } op_t;
  op_t expq[$];

  int checks = 0, errors = 0;
  int lat = 1, busy_polls = 0, poll_i = 0;
  bit cur_wr = 0, last_flag = 0, pend = 0;
  int cnt = 0;
  logic [15:0] resp;
  logic [15:0] sdata [4];
  bit m_ok = 0;
  logic [7:0] m_page = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // lower-engine responder and per-clock comparison with the expected operation list
  initial begin
    forever begin
      @(negedge clk);
      if (mg_done) begin
        mg_done = 0;
        if (last_flag) begin
          chk(done === 1'b1, "R11 done right after final answer", done, 1);
          last_flag = 0;
        end
      end
      if (pend) begin
        if (cnt == 0) begin
          mg_done = 1; mg_rdata = resp; pend = 0;
          if (expq.size() == 0) last_flag = 1;
        end else cnt--;
      end
      if (mg_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R9/R10 unexpected management operation", mg_reg, 0);
        end else begin
          op_t e;
          e = expq.pop_front();
          chk(mg_phy == 5'h1E, "R1 phy address", mg_phy, 5'h1E);
          chk(mg_reg == e.r && mg_write == e.w, "R2-order register/direction (R3 R7)",
              {mg_write, mg_reg}, {e.w, e.r});
          if (e.w) chk(mg_wdata == e.d, "R3/R4 write data", mg_wdata, e.d);
        end
        if (!mg_write && mg_reg == 5'h11) begin
          resp = (poll_i < busy_polls) ? (16'hA500 | (cur_wr ? 16'h1 : 16'h2)) : 16'hA5FC;
          poll_i++;
        end else if (!mg_write) resp = sdata[mg_reg - 5'h18];
        else resp = 16'hDEAD;
        pend = 1; cnt = lat - 1;
      end
    end
  end

  function automatic int hi_of(input logic [3:0] l);
    case (l) 4'd1, 4'd2: return 0; 4'd4: return 1; 4'd6: return 2; 4'd8: return 3; default: return -1; endcase
  endfunction

  task automatic run_req(input bit wr, input logic [7:0] pg, input logic [7:0] rg,
                         input logic [3:0] ln, input logic [63:0] wd, input int bp, input bit spur);
    int hi, np, w;
    bit tmo;
    logic [63:0] exp_rd;
    op_t o;
    hi = hi_of(ln);
    exp_rd = 0;
    tmo = 0;
    if (hi >= 0) begin
      if (!(m_ok && m_page == pg)) begin o.r = 5'h10; o.w = 1; o.d = {pg, 8'h01}; expq.push_back(o); end
      if (wr) for (int i = hi; i >= 0; i--) begin
        o.r = 5'h18 + 5'(i); o.w = 1;
        o.d = (ln == 1) ? {8'h00, wd[7:0]} : wd[16*i +: 16];
        expq.push_back(o);
      end
      o.r = 5'h11; o.w = 1; o.d = {rg, wr ? 8'h01 : 8'h02}; expq.push_back(o);
      tmo = bp >= 100;
      np = tmo ? 100 : bp + 1;
      for (int i = 0; i < np; i++) begin o.r = 5'h11; o.w = 0; o.d = 0; expq.push_back(o); end
      if (!wr && !tmo) for (int i = hi; i >= 0; i--) begin
        o.r = 5'h18 + 5'(i); o.w = 0; o.d = 0; expq.push_back(o);
        exp_rd[16*i +: 16] = (ln == 1) ? {8'h00, sdata[i][7:0]} : sdata[i];
      end
    end
    busy_polls = bp; poll_i = 0; cur_wr = wr;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_page = pg; req_reg = rg; req_len = ln; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (hi < 0) begin
      chk(done === 1'b1 && err === 1'b1, "R9 illegal length rejected next cycle", {done, err}, 2'b11);
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R9 no access started", busy, 0);
      return;
    end
    chk(busy === 1'b1, "R11 busy after accept", busy, 1);
    if (spur) begin
      repeat (2) @(negedge clk);
      req_valid = 1; req_write = 1; req_page = pg + 8'd7; req_reg = 8'h55; req_len = 4'd8;
      @(negedge clk);
      req_valid = 0;
    end
    w = 0;
    while (done !== 1'b1 && w < 2000) begin @(negedge clk); w++; end
    chk(done === 1'b1, "R11 access completes", done, 1);
    chk(err === tmo, tmo ? "R6 timeout error" : "R6 no error on completion", err, tmo);
    chk(rdata === exp_rd, wr ? "R7 rdata zero after write" : "R7 assembled read data", rdata, exp_rd);
    chk(expq.size() == 0, "R8 operation count", expq.size(), 0);
    @(negedge clk);
    chk(done === 1'b0, "R11 done is a pulse", done, 0);
    if (!tmo) begin m_ok = 1; m_page = pg; end
  endtask

  initial begin
    int wd_cnt = 0;
    forever begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    sdata[0] = 16'h1A2B; sdata[1] = 16'h3C4D; sdata[2] = 16'h5E6F; sdata[3] = 16'h7081;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && mg_valid === 0, "R11 reset state idle", {busy, done, mg_valid}, 0);
    // R9 illegal length straight after reset, cache must stay empty
    run_req(0, 8'h02, 8'h30, 4'd3, 64'h0, 0, 0);
    // R2 empty cache forces a page write
    lat = 2;
    run_req(0, 8'h02, 8'h30, 4'd2, 64'h0, 2, 0);
    // R3 R8 eight-byte write on same page, no page write
    run_req(1, 8'h02, 8'h40, 4'd8, 64'h0123_4567_89AB_CDEF, 0, 0);
    // R3 one-byte write keeps only low byte
    lat = 1;
    run_req(1, 8'h02, 8'h41, 4'd1, 64'hFFFF_FFFF_FFFF_FF12, 1, 0);
    // R7 R8 read lengths
    run_req(0, 8'h02, 8'h10, 4'd8, 64'h0, 3, 0);
    lat = 3;
    run_req(0, 8'h02, 8'h11, 4'd6, 64'h0, 0, 0);
    run_req(0, 8'h02, 8'h12, 4'd4, 64'h0, 1, 0);
    run_req(0, 8'h02, 8'h13, 4'd1, 64'h0, 0, 0);
    // R2 page change, R3 four-byte write
    lat = 1;
    run_req(1, 8'h00, 8'h0B, 4'd4, 64'h0000_0000_CAFE_F00D, 4, 0);
    run_req(1, 8'h00, 8'h0C, 4'd6, 64'h0000_1111_2222_3333, 0, 0);
    // R6 timeout, then same page must be selected again
    run_req(0, 8'h05, 8'h22, 4'd2, 64'h0, 500, 0);
    run_req(0, 8'h05, 8'h22, 4'd2, 64'h0, 99, 0);
    // R9 illegal lengths with a valid cache
    run_req(1, 8'h05, 8'h01, 4'd0, 64'h0, 0, 0);
    run_req(0, 8'h05, 8'h01, 4'd9, 64'h0, 0, 0);
    run_req(0, 8'h05, 8'h03, 4'd1, 64'h0, 0, 0);
    // R11 request while busy is ignored
    lat = 2;
    run_req(1, 8'h05, 8'h33, 4'd2, 64'h0000_0000_0000_BEEF, 2, 1);
    run_req(0, 8'h05, 8'h34, 4'd2, 64'h0, 0, 0);
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule